// File: doc/BRIEF.md
# Dual Boot Memory Failover Controller

This block decides which of two redundant boot memories answers the processor's boot fetches. Both memories sit in one address window. The block tells them apart only by driving one of two chip selects whenever that window is decoded. A built-in watchdog supervises each boot attempt. If the boot code does not service the watchdog in time, the block requests a system reset and moves to the next step of a fixed sequence: primary, then secondary, then primary again, then halt.

The failure is recorded in a status bit that survives every reset except a power event, so software can find out later that the boot did not go cleanly. When the boot firmware finishes, it writes a completion bit. That write stops the watchdog and hands the choice of memory to a software-controlled select bit, so both memories can be reached in normal operation. Reset causes arrive as one-cycle strobes. Each causes a reset request of fixed length, and the cause decides how much of the boot history is kept.

Top module: `boot_failover_ctrl`

## Requirements
- R1: After `rst`, or a strobe on `rst_pwrup` or `rst_pfail`, the primary memory is selected. The attempt count is 0, the failure flag and halt are clear, boot-complete and software-select are 0, and the timeout multiple register reads 1.
- R2: During boot, the watchdog times out after BASE_TICKS*M clock cycles without service. M is register address 1, bits [3:0]. A value of 0 acts as 1.
- R3: A strobe on `wdt_kick` restarts the watchdog count, so a timeout falls exactly BASE_TICKS*M cycles after the last service.
- R4: The first timeout selects the secondary memory, sets the failure flag and starts a reset request.
- R5: The second timeout selects the primary memory again. The third raises `halt` with no reset request and no chip select. While halted, no further reset request appears.
- R6: The failure flag is cleared only by `rst`, `rst_pwrup` or `rst_pfail`. Watchdog timeouts and soft reset causes keep it.
- R7: A strobe on any of `rst_sw`, `rst_button`, `rst_jtag` or `rst_superv` restarts the boot sequence. It selects the primary memory with attempt count 0, clears `halt` and boot-complete, and starts a reset request.
- R8: Every reset request lasts exactly RST_PULSE (16) cycles. This includes requests caused by power events.
- R9: Writing 1 to register address 0, bit 0 (boot-complete, sticky) stops the watchdog. After that, register address 0, bit 1 selects the memory (1 = secondary).
- R10: A chip select is active only while `flash_sel` is high and `halt` is low. The two chip selects are never active together.
- R11: The status register at address 2 reads bit 0 = failure flag, bits [2:1] = attempt count, bit 3 = halt, bit 4 = secondary memory currently selected. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, full clear |
| rst_pwrup | input | 1 | Power-up reset cause strobe |
| rst_pfail | input | 1 | Power-fail reset cause strobe |
| rst_sw | input | 1 | Software reset cause strobe |
| rst_button | input | 1 | Push-button reset cause strobe |
| rst_jtag | input | 1 | Debug-port reset cause strobe |
| rst_superv | input | 1 | Supervisor reset cause strobe |
| wdt_kick | input | 1 | Watchdog service strobe |
| flash_sel | input | 1 | Boot memory address window decoded |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cs_pri | output | 1 | Primary memory chip select |
| cs_sec | output | 1 | Secondary memory chip select |
| sys_rst_req | output | 1 | System reset request |
| halt | output | 1 | Processor halt indication |

## Verification
A timeout's effects appear right after the clock edge on which the BASE_TICKS*M-th counting cycle completes. Counting starts on the first edge after `rst` is released, after a service strobe, or after a reset request ends. The reset request, the new chip select and the status update all arrive on that same edge. The reset request then stays high for exactly 16 sampled cycles. The bench counts edges from each of those starting points and compares the count with the exact value. For the third timeout, it checks `halt` one edge early and on the edge itself. Register writes and reset strobes take effect on the edge that samples them, so every check is made 1 ns after that edge.

// File: rtl/boot_failover_pkg.sv
package boot_failover_pkg;

    typedef enum logic [1:0] {
        ATT_PRI0 = 2'd0,
        ATT_SEC  = 2'd1,
        ATT_PRI1 = 2'd2
    } attempt_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       sec_active;
        logic       halted;
        logic [1:0] attempt;
        logic       fail;
    } status_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MULT = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    function automatic logic sel_secondary(attempt_e a);
        return a == ATT_SEC;
    endfunction

    function automatic attempt_e next_attempt(attempt_e a);
        case (a)
            ATT_PRI0: return ATT_SEC;
            ATT_SEC:  return ATT_PRI1;
            default:  return ATT_PRI1;
        endcase
    endfunction

endpackage

// File: rtl/bfo_watchdog.sv
module bfo_watchdog #(
    parameter int BASE_TICKS = 160_000_000,
    parameter int MULT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [MULT_W-1:0] mult,
    output logic              timeout
);
    localparam int BW = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;
    localparam logic [BW-1:0] BMAX = BW'(BASE_TICKS - 1);

    logic [BW-1:0]     base_cnt;
    logic [MULT_W-1:0] mult_cnt;
    logic [MULT_W-1:0] mult_lim;

    assign mult_lim = (mult == '0) ? '0 : mult - 1'b1;
    assign timeout  = en && !clr && (base_cnt == BMAX) && (mult_cnt == mult_lim);

    always_ff @(posedge clk) begin
        if (rst || clr || !en || timeout) begin
            base_cnt <= '0;
            mult_cnt <= '0;
        end else if (base_cnt == BMAX) begin
            base_cnt <= '0;
            mult_cnt <= mult_cnt + 1'b1;
        end else begin
            base_cnt <= base_cnt + 1'b1;
        end
    end

    AST_WD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (clr || !en) |=> (base_cnt == '0 && mult_cnt == '0)); // R3

endmodule

// File: rtl/bfo_seq.sv
module bfo_seq
    import boot_failover_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hard_evt,
    input  logic     soft_evt,
    input  logic     timeout,
    output attempt_e attempt,
    output logic     halt,
    output logic     fail,
    output logic     rst_req
);
    localparam int PW = $clog2(RST_PULSE + 1);

    logic [PW-1:0] pulse_cnt;

    assign rst_req = (pulse_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            attempt   <= ATT_PRI0;
            halt      <= 1'b0;
            fail      <= 1'b0;
            pulse_cnt <= '0;
        end else if (hard_evt) begin
            attempt   <= ATT_PRI0;
            halt      <= 1'b0;
            fail      <= 1'b0;
            pulse_cnt <= PW'(RST_PULSE);
        end else if (soft_evt) begin
            attempt   <= ATT_PRI0;
            halt      <= 1'b0;
            pulse_cnt <= PW'(RST_PULSE);
        end else if (timeout) begin
            fail <= 1'b1;
            if (attempt == ATT_PRI1) begin
                halt <= 1'b1;
            end else begin
                attempt   <= next_attempt(attempt);
                pulse_cnt <= PW'(RST_PULSE);
            end
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    AST_ATTEMPT_STEP: assert property (@(posedge clk) disable iff (rst)
        (timeout && attempt != ATT_PRI1 && !hard_evt && !soft_evt)
        |=> (attempt == next_attempt($past(attempt)) && rst_req)); // R4
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (halt && !rst_req && !hard_evt && !soft_evt) |=> !rst_req); // R5
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !hard_evt) |=> fail); // R6
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pulse_cnt > 1) |=> rst_req); // R8

endmodule

// File: rtl/bfo_regs.sv
module bfo_regs
    import boot_failover_pkg::*;
#(
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_evt,
    input  logic              soft_evt,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  status_t           status,
    output logic              boot_done,
    output logic              sw_sel,
    output logic [MULT_W-1:0] mult,
    output logic [7:0]        rdata
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst || hard_evt) begin
            boot_done <= 1'b0;
            sw_sel    <= 1'b0;
            mult      <= MULT_W'(1);
        end else if (soft_evt) begin
            boot_done <= 1'b0;
            sw_sel    <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_CTRL) begin
                boot_done <= boot_done | wdata[0];
                sw_sel    <= wdata[1];
            end else if (addr == ADDR_MULT) begin
                mult <= wdata[MULT_W-1:0];
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {6'b0, sw_sel, boot_done};
            ADDR_MULT: rdata = {{(8-MULT_W){1'b0}}, mult};
            ADDR_STAT: rdata = status;
            default:   rdata = 8'h00;
        endcase
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (boot_done && !hard_evt && !soft_evt) |=> boot_done); // R9

endmodule

// File: rtl/boot_failover_ctrl.sv
module boot_failover_ctrl
    import boot_failover_pkg::*;
#(
    parameter int BASE_TICKS = 160_000_000,
    parameter int MULT_W     = 4,
    parameter int RST_PULSE  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pwrup,
    input  logic       rst_pfail,
    input  logic       rst_sw,
    input  logic       rst_button,
    input  logic       rst_jtag,
    input  logic       rst_superv,
    input  logic       wdt_kick,
    input  logic       flash_sel,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cs_pri,
    output logic       cs_sec,
    output logic       sys_rst_req,
    output logic       halt
);
    logic              hard_evt, soft_evt, timeout, wd_en, wd_clr;
    logic              boot_done, sw_sel, fail, dev_sec;
    logic [MULT_W-1:0] mult;
    attempt_e          attempt;
    status_t           status;

    assign hard_evt = rst_pwrup | rst_pfail;
    assign soft_evt = rst_sw | rst_button | rst_jtag | rst_superv;
    assign wd_en    = !boot_done && !halt && !sys_rst_req;
    assign wd_clr   = wdt_kick | hard_evt | soft_evt;

    bfo_watchdog #(.BASE_TICKS(BASE_TICKS), .MULT_W(MULT_W)) i_wd (
        .clk(clk), .rst(rst), .en(wd_en), .clr(wd_clr), .mult(mult), .timeout(timeout)
    );

    bfo_seq #(.RST_PULSE(RST_PULSE)) i_seq (
        .clk(clk), .rst(rst), .hard_evt(hard_evt), .soft_evt(soft_evt),
        .timeout(timeout), .attempt(attempt), .halt(halt), .fail(fail),
        .rst_req(sys_rst_req)
    );

    assign dev_sec = boot_done ? sw_sel : sel_secondary(attempt);

    always_comb begin
        status            = '0;
        status.fail       = fail;
        status.attempt    = attempt;
        status.halted     = halt;
        status.sec_active = dev_sec;
    end

    bfo_regs #(.MULT_W(MULT_W)) i_regs (
        .clk(clk), .rst(rst), .hard_evt(hard_evt), .soft_evt(soft_evt),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .status(status),
        .boot_done(boot_done), .sw_sel(sw_sel), .mult(mult), .rdata(reg_rdata)
    );

    assign cs_pri = flash_sel && !halt && !dev_sec;
    assign cs_sec = flash_sel && !halt && dev_sec;

    AST_CS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_pri, cs_sec})); // R10
    AST_CS_GATED: assert property (@(posedge clk) disable iff (rst)
        (cs_pri || cs_sec) |-> (flash_sel && !halt)); // R10

endmodule

// File: tb/test_boot_failover_ctrl.sv
module test_boot_failover_ctrl;
    localparam int BASE = 20;
    localparam int PULSE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pwrup = 0, rst_pfail = 0, rst_sw = 0, rst_button = 0, rst_jtag = 0, rst_superv = 0;
    logic wdt_kick = 0, flash_sel = 1, reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic cs_pri, cs_sec, sys_rst_req, halt;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    boot_failover_ctrl #(.BASE_TICKS(BASE), .MULT_W(4), .RST_PULSE(PULSE)) i_boot_failover_ctrl (
        .clk(clk), .rst(rst), .rst_pwrup(rst_pwrup), .rst_pfail(rst_pfail),
        .rst_sw(rst_sw), .rst_button(rst_button), .rst_jtag(rst_jtag),
        .rst_superv(rst_superv), .wdt_kick(wdt_kick), .flash_sel(flash_sel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cs_pri(cs_pri), .cs_sec(cs_sec),
        .sys_rst_req(sys_rst_req), .halt(halt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output int v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic kick();
        @(negedge clk); wdt_kick = 1;
        @(posedge clk); #1 wdt_kick = 0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: rst_sw = 1; 1: rst_button = 1; 2: rst_jtag = 1;
            3: rst_superv = 1; 4: rst_pwrup = 1; default: rst_pfail = 1;
        endcase
        @(posedge clk); #1;
        {rst_sw, rst_button, rst_jtag, rst_superv, rst_pwrup, rst_pfail} = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk); rst = 0;
    endtask

    task automatic count_to_rise(output int n);
        n = 0;
        do begin
            @(posedge clk); #1 n++;
        end while (!sys_rst_req && n < 500);
    endtask

    task automatic count_high(output int n);
        n = 1;
        forever begin
            @(posedge clk); #1;
            if (!sys_rst_req || n > 100) break;
            n++;
        end
    endtask

    task automatic quiet(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (sys_rst_req) seen = 1;
        end
    endtask

    task automatic t_reset_state();
        int v;
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        read_reg(2, v); chk("R1 status after reset", v, 0);
        read_reg(0, v); chk("R1 ctrl after reset", v, 0);
        read_reg(1, v); chk("R1 multiple after reset", v, 1);
        chk("R1 primary cs", cs_pri, 1);
        chk("R1 secondary cs", cs_sec, 0);
        chk("R1 reset request idle", sys_rst_req, 0);
        chk("R1 halt idle", halt, 0);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_failover();
        int n, v;
        do_reset();
        count_to_rise(n); chk("R2 first timeout cycles", n, BASE);
        read_reg(2, v); chk("R4 R11 status after first timeout", v, 8'h13);
        chk("R4 secondary cs", cs_sec, 1);
        chk("R4 primary cs off", cs_pri, 0);
        count_high(n); chk("R8 pulse length after timeout", n, PULSE);
        count_to_rise(n); chk("R5 second timeout cycles", n, BASE);
        read_reg(2, v); chk("R5 R6 status after second timeout", v, 8'h05);
        chk("R5 primary again", cs_pri, 1);
        count_high(n); chk("R8 second pulse length", n, PULSE);
        repeat (BASE - 1) @(posedge clk);
        #1 chk("R5 no halt before third timeout", halt, 0);
        @(posedge clk); #1;
        chk("R5 halt on third timeout", halt, 1);
        chk("R5 no reset request at halt", sys_rst_req, 0);
        chk("R5 R10 no cs while halted", cs_pri | cs_sec, 0);
        read_reg(2, v); chk("R11 status halted", v, 8'h0D);
        quiet(3 * BASE, v); chk("R5 silent while halted", v, 0);
        strobe(2);
        chk("R7 soft reset request", sys_rst_req, 1);
        chk("R7 halt cleared", halt, 0);
        chk("R7 primary selected", cs_pri, 1);
        read_reg(2, v); chk("R6 R7 status after soft reset", v, 8'h01);
        count_high(n); chk("R8 pulse length soft reset", n, PULSE);
        count_to_rise(n); chk("R7 sequence restarts", n, BASE);
        read_reg(2, v); chk("R6 fail kept, secondary again", v, 8'h13);
        count_high(n);
        strobe(5);
        read_reg(2, v); chk("R1 power-fail clears status", v, 0);
        count_high(n); chk("R8 pulse length power-fail", n, PULSE);
        strobe(4);
        read_reg(1, v); chk("R1 power-up restores multiple", v, 1);
        count_high(n); chk("R8 pulse length power-up", n, PULSE);
    endtask

    task automatic t_kick();
        int n, v;
        do_reset();
        v = 0;
        for (int k = 0; k < 8; k++) begin
            kick();
            repeat (BASE / 2) begin @(posedge clk); #1 if (sys_rst_req) v = 1; end
        end
        chk("R3 service prevents timeout", v, 0);
        kick();
        count_to_rise(n); chk("R3 timeout measured from last service", n, BASE);
        count_high(n);
        strobe(1);
        read_reg(2, v); chk("R7 button reset restores primary", v, 8'h01);
        count_high(n);
        strobe(3);
        chk("R7 supervisor strobe requests reset", sys_rst_req, 1);
        count_high(n);
        strobe(0);
        chk("R7 software strobe requests reset", sys_rst_req, 1);
        count_high(n);
    endtask

    task automatic t_multiple();
        int n, v;
        do_reset();
        write_reg(1, 8'h03);
        read_reg(1, v); chk("R2 multiple readback", v, 3);
        kick();
        count_to_rise(n); chk("R2 timeout with multiple 3", n, 3 * BASE);
        do_reset();
        write_reg(1, 8'h00);
        kick();
        count_to_rise(n); chk("R2 multiple 0 acts as 1", n, BASE);
    endtask

    task automatic t_boot_done();
        int v;
        do_reset();
        write_reg(0, 8'h01);
        read_reg(0, v); chk("R9 boot complete readback", v, 1);
        quiet(4 * BASE, v); chk("R9 watchdog stopped", v, 0);
        chk("R9 software select primary", cs_pri, 1);
        write_reg(0, 8'h02);
        chk("R9 software select secondary", cs_sec, 1);
        chk("R9 R10 primary off", cs_pri, 0);
        read_reg(0, v); chk("R9 boot complete sticky", v, 3);
        read_reg(2, v); chk("R11 secondary active bit", v, 8'h10);
        flash_sel = 0; #1;
        chk("R10 no cs outside window", cs_pri | cs_sec, 0);
        flash_sel = 1;
        write_reg(0, 8'h00);
        chk("R9 back to primary", cs_pri, 1);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_failover();
        t_kick();
        t_multiple();
        t_boot_done();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule